// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of consecutive bytes from a one-time-programmable fuse macro. It does this entirely in hardware, so no processor has to toggle the macro's control lines in software. A host supplies a start address and a byte count and pulses a start request. The block then drives the fuse macro's control word through a fixed pattern. The macro is selected with programming held off, the load line is raised, and each byte is addressed, strobed, sampled and released in turn. Finally the macro is deselected.

Every wait inside the pattern is a whole number of microseconds, measured by one down-counter. The number of clock cycles per microsecond is a parameter. Each byte that is read leaves the block on a data output with a one-cycle valid pulse, in address order. Bits 1:0 of the byte at a chosen position in the session are also kept in a status register. In the usual set-up that byte is the one marking a defective on-chip PLL, and the register holds its value after the read has finished.

A session with a zero count performs no read. It reports completion at once and leaves the fuse pins at rest. Start requests that arrive while a session is running are ignored.

Top module: `fuse_rd_seq`

## Requirements
- R1: Out of reset, and whenever busy_o is low, fuse_ctrl_o equals 14'h0001 (macro deselected, all other bits low), and done_o and byte_valid_o are low. After reset flag_o is 2'b00.
- R2: Control word fields: bit 0 is select (active low), bit 1 is strobe (active high), bit 2 is load (active high), bit 3 is program enable (active low), bits 13:6 are the fuse address, and bits 5:4 are always 0. While select is low, bit 3 is 1 and bit 2 is 1.
- R3: Strobe is high for exactly 2*CYCLES_PER_US cycles for each byte. The address field is stable throughout and for 2*CYCLES_PER_US cycles before strobe rises.
- R4: Each byte is the fuse output sampled in the last cycle of its strobe-high window. It appears on byte_o with byte_valid_o high for one cycle, in the cycle after strobe falls.
- R5: A session with count N > 0 returns exactly N bytes, from addresses start, start+1, and so on, with the address wrapping modulo 256.
- R6: For N > 0, done_o is high in the cycle that follows start capture by 2*CYCLES_PER_US*(3N+2) + CYCLES_PER_US cycles. This covers the load phase, three phases per byte, the tail wait and the deselect hold.
- R7: A start with count 0 raises done_o in the cycle right after start is captured, and fuse_ctrl_o stays 14'h0001 throughout.
- R8: busy_o is high from the cycle after start capture up to and including the done_o cycle. A start request while busy_o is high has no effect on the bytes returned or on the timing.
- R9: done_o is a single-cycle pulse, and the block is idle (busy_o low) in the next cycle.
- R10: When a session reaches session byte index FLAG_IDX (counting from 0), flag_o takes bits 1:0 of that byte. Otherwise flag_o keeps its value, including across sessions too short to reach that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| addr_i | input | 8 | First fuse address |
| count_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fuse_ctrl_o | output | 14 | Fuse macro control word |
| fuse_dout_i | input | 8 | Fuse macro data output |
| byte_o | output | 8 | Last byte read |
| byte_valid_o | output | 1 | byte_o valid strobe |
| flag_o | output | 2 | Bits 1:0 of the byte at index FLAG_IDX |

## Verification
The bench builds the block with CYCLES_PER_US = 2 and FLAG_IDX = 3. With these values each wait lasts only a few cycles, so a single run can read the full 256-byte address space and cover the wrap from 255 to 0. It also runs a sweep of byte counts from 0 to 7, plus sessions that end just before and just after the flag index. The behavioural fuse model returns an arithmetic function of the address. This lets every byte, the cycle in which done appears, and the strobe widths be predicted exactly.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_ASET, ST_STRB, ST_REL, ST_TAIL, ST_DESEL, ST_DONE
  } seq_state_e;

  // control word bit positions, decoded by the fuse macro
  localparam int unsigned CW_CSN      = 0;
  localparam int unsigned CW_STRB     = 1;
  localparam int unsigned CW_LOAD     = 2;
  localparam int unsigned CW_PGMN     = 3;
  localparam int unsigned CW_ADDR_LSB = 6;
endpackage

// File: rtl/fuse_gap_timer.sv
module fuse_gap_timer #(
  parameter int unsigned CYCLES_PER_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic expired_o
);
  localparam int unsigned LONG_CYC  = 2 * CYCLES_PER_US;
  localparam int unsigned SHORT_CYC = CYCLES_PER_US;
  localparam int unsigned TMR_W     = $clog2(LONG_CYC + 1);
  localparam logic [TMR_W-1:0] LONG_TERM  = TMR_W'(LONG_CYC - 1);
  localparam logic [TMR_W-1:0] SHORT_TERM = TMR_W'(SHORT_CYC - 1);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= long_i ? LONG_TERM : SHORT_TERM;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fuse_rd_fsm.sv
module fuse_rd_fsm
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              tmr_exp_i,
  output logic              tmr_load_o,
  output logic              tmr_long_o,
  output logic              capture_o,
  output logic [CNT_W-1:0]  byte_idx_o,
  output seq_state_e        state_q_o,
  output seq_state_e        state_d_o,
  output logic [ADDR_W-1:0] addr_d_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [CNT_W-1:0]  idx_q, idx_d;

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    remain_d   = remain_q;
    idx_d      = idx_q;
    tmr_load_o = 1'b0;
    tmr_long_o = 1'b1;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (count_i == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d    = ST_LOAD;
            addr_d     = addr_i;
            remain_d   = count_i;
            idx_d      = '0;
            tmr_load_o = 1'b1;
          end
        end
      end
      ST_LOAD: if (tmr_exp_i) begin
        state_d    = ST_ASET;
        tmr_load_o = 1'b1;
      end
      ST_ASET: if (tmr_exp_i) begin
        state_d    = ST_STRB;
        tmr_load_o = 1'b1;
      end
      ST_STRB: if (tmr_exp_i) begin
        state_d    = ST_REL;
        tmr_load_o = 1'b1;
        capture_o  = 1'b1;
      end
      ST_REL: if (tmr_exp_i) begin
        tmr_load_o = 1'b1;
        if (remain_q == CNT_W'(1)) begin
          state_d = ST_TAIL;
        end else begin
          state_d  = ST_ASET;
          remain_d = remain_q - 1'b1;
          addr_d   = addr_q + 1'b1;
          idx_d    = idx_q + 1'b1;
        end
      end
      ST_TAIL: if (tmr_exp_i) begin
        state_d    = ST_DESEL;
        tmr_load_o = 1'b1;
        tmr_long_o = 1'b0;
      end
      ST_DESEL: if (tmr_exp_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      idx_q    <= '0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      idx_q    <= idx_d;
    end
  end

  assign byte_idx_o = idx_q;
  assign state_q_o  = state_q;
  assign state_d_o  = state_d;
  assign addr_d_o   = addr_d;
endmodule

// File: rtl/fuse_pin_drv.sv
module fuse_pin_drv
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  seq_state_e                  state_d_i,
  input  logic [ADDR_W-1:0]           addr_d_i,
  output logic [CW_ADDR_LSB+ADDR_W-1:0] ctrl_o
);
  localparam int unsigned CW_W = CW_ADDR_LSB + ADDR_W;
  localparam logic [CW_W-1:0] IDLE_WORD = CW_W'(1) << CW_CSN;

  logic [CW_W-1:0] ctrl_d, ctrl_q;

  // encoded from next state so pins leave a flop, glitch free
  always_comb begin
    ctrl_d = '0;
    unique case (state_d_i)
      ST_IDLE, ST_DONE: ctrl_d[CW_CSN] = 1'b1;
      ST_LOAD: begin
        ctrl_d[CW_LOAD] = 1'b1;
        ctrl_d[CW_PGMN] = 1'b1;
      end
      ST_ASET, ST_REL, ST_TAIL: begin
        ctrl_d[CW_LOAD] = 1'b1;
        ctrl_d[CW_PGMN] = 1'b1;
        ctrl_d[CW_ADDR_LSB +: ADDR_W] = addr_d_i;
      end
      ST_STRB: begin
        ctrl_d[CW_LOAD] = 1'b1;
        ctrl_d[CW_PGMN] = 1'b1;
        ctrl_d[CW_STRB] = 1'b1;
        ctrl_d[CW_ADDR_LSB +: ADDR_W] = addr_d_i;
      end
      ST_DESEL: begin
        ctrl_d[CW_CSN]  = 1'b1;
        ctrl_d[CW_LOAD] = 1'b1;
        ctrl_d[CW_PGMN] = 1'b1;
        ctrl_d[CW_ADDR_LSB +: ADDR_W] = addr_d_i;
      end
      default: ctrl_d = IDLE_WORD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= IDLE_WORD;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/fuse_byte_cap.sv
module fuse_byte_cap #(
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned FLAG_IDX = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [7:0]       dout_i,
  output logic [7:0]       byte_o,
  output logic             valid_o,
  output logic [1:0]       flag_o
);
  localparam logic [CNT_W-1:0] FLAG_POS = CNT_W'(FLAG_IDX);

  logic [7:0] byte_q;
  logic       valid_q;
  logic [1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q  <= '0;
      valid_q <= 1'b0;
      flag_q  <= '0;
    end else begin
      valid_q <= capture_i;
      if (capture_i) byte_q <= dout_i;
      if (capture_i && idx_i == FLAG_POS) flag_q <= dout_i[1:0];
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int unsigned CYCLES_PER_US = 100,
  parameter int unsigned CNT_W         = 9,
  parameter int unsigned FLAG_IDX      = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       addr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [13:0]      fuse_ctrl_o,
  input  logic [7:0]       fuse_dout_i,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic [1:0]       flag_o
);
  localparam int unsigned ADDR_W = 8;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  byte_idx;
  logic              tmr_load, tmr_long, tmr_exp, capture;

  fuse_gap_timer #(.CYCLES_PER_US(CYCLES_PER_US)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .long_i    (tmr_long),
    .expired_o (tmr_exp)
  );

  fuse_rd_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .count_i    (count_i),
    .tmr_exp_i  (tmr_exp),
    .tmr_load_o (tmr_load),
    .tmr_long_o (tmr_long),
    .capture_o  (capture),
    .byte_idx_o (byte_idx),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .addr_d_o   (addr_d)
  );

  fuse_pin_drv #(.ADDR_W(ADDR_W)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .addr_d_i  (addr_d),
    .ctrl_o    (fuse_ctrl_o)
  );

  fuse_byte_cap #(.CNT_W(CNT_W), .FLAG_IDX(FLAG_IDX)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .idx_i     (byte_idx),
    .dout_i    (fuse_dout_i),
    .byte_o    (byte_o),
    .valid_o   (byte_valid_o),
    .flag_o    (flag_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk #(
  parameter int unsigned CYCLES_PER_US = 100
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic [13:0] fuse_ctrl_o,
  input logic        byte_valid_o,
  input logic [1:0]  flag_o
);
  localparam int unsigned LONG_CYC = 2 * CYCLES_PER_US;

  logic        strb;
  logic [15:0] strb_len_q;

  assign strb = fuse_ctrl_o[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   strb_len_q <= '0;
    else if (strb) strb_len_q <= strb_len_q + 1'b1;
    else           strb_len_q <= '0;
  end

  assert_idle_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fuse_ctrl_o == 14'h0001 && !byte_valid_o));

  assert_no_program_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fuse_ctrl_o[0] |-> (fuse_ctrl_o[3] && fuse_ctrl_o[2] && fuse_ctrl_o[5:4] == 2'b00));

  assert_strobe_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb) |-> (strb_len_q == 16'(LONG_CYC)));

  assert_addr_steady_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb |-> $stable(fuse_ctrl_o[13:6]));

  assert_valid_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> (!strb && $past(strb)));

  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o |-> $stable(flag_o));
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.CYCLES_PER_US(CYCLES_PER_US)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fuse_ctrl_o  (fuse_ctrl_o),
  .byte_valid_o (byte_valid_o),
  .flag_o       (flag_o)
);

// File: tb/fuse_rd_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_rd_seq_tb_top;
  localparam int unsigned CPU   = 2;
  localparam int unsigned CNT_W = 9;
  localparam int unsigned FIDX  = 3;
  localparam int unsigned G2    = 2 * CPU;
  localparam int unsigned G1    = CPU;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [7:0]       addr_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic             busy_o, done_o, byte_valid_o;
  logic [13:0]      fuse_ctrl_o;
  logic [7:0]       fuse_dout_i, byte_o;
  logic [1:0]       flag_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] exp_flag = 2'b00;

  always #2 clk_i = ~clk_i;

  fuse_rd_seq #(.CYCLES_PER_US(CPU), .CNT_W(CNT_W), .FLAG_IDX(FIDX)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .count_i      (count_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fuse_ctrl_o  (fuse_ctrl_o),
    .fuse_dout_i  (fuse_dout_i),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .flag_o       (flag_o)
  );

  function automatic logic [7:0] fuse_val(input logic [7:0] a);
    logic [7:0] m;
    m = a * 8'd37 + 8'd11;
    return m ^ {3'b000, a[7:3]};
  endfunction

  // behavioural fuse macro: data valid while selected and strobed
  always_comb
    fuse_dout_i = (!fuse_ctrl_o[0] && fuse_ctrl_o[1] && fuse_ctrl_o[2])
                  ? fuse_val(fuse_ctrl_o[13:6]) : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic run_session(input logic [7:0] a, input int n, input bit poke);
    int k = 0;
    int got = 0;
    int strb_run = 0;
    int bad_ctrl = 0;
    int bad_strb = 0;
    int bad_busy = 0;
    int bad_zero = 0;
    int exp_lat;
    logic [7:0] ea;
    exp_lat = (n == 0) ? 0 : G2 * (3 * n + 2) + G1;
    @(negedge clk_i);
    start_i = 1'b1; addr_i = a; count_i = CNT_W'(n);
    @(negedge clk_i);
    start_i = 1'b0; count_i = '0; addr_i = ~a;
    while (!done_o && k < 20000) begin
      if (byte_valid_o) begin
        ea = a + 8'(got);
        chk(byte_o == fuse_val(ea), "R4/R5 byte data", byte_o, fuse_val(ea));
        got++;
      end
      if (!fuse_ctrl_o[0] && (!fuse_ctrl_o[3] || !fuse_ctrl_o[2] || fuse_ctrl_o[5:4] != 2'b00))
        bad_ctrl++;
      if (fuse_ctrl_o[1]) strb_run++;
      else if (strb_run != 0) begin
        if (strb_run != int'(G2)) bad_strb++;
        strb_run = 0;
      end
      if (!busy_o) bad_busy++;
      if (n == 0 && fuse_ctrl_o != 14'h0001) bad_zero++;
      k++;
      @(negedge clk_i);
      if (poke && k == 3) begin start_i = 1'b1; addr_i = a + 8'd100; count_i = CNT_W'(1); end
      if (poke && k == 4) begin start_i = 1'b0; count_i = '0; end
    end
    chk(k == exp_lat, "R6 done latency", k, exp_lat);
    chk(got == n, "R5 byte count", got, n);
    chk(bad_ctrl == 0, "R2 control word while selected", bad_ctrl, 0);
    chk(bad_strb == 0, "R3 strobe width", bad_strb, 0);
    chk(bad_busy == 0 && busy_o, "R8 busy through session", bad_busy, 0);
    if (n == 0) begin
      chk(bad_zero == 0 && fuse_ctrl_o == 14'h0001, "R7 zero count pins idle", fuse_ctrl_o, 1);
    end
    if (n > int'(FIDX)) exp_flag = fuse_val(a + 8'(FIDX)) & 8'h03;
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R9 single done pulse", {done_o, busy_o}, 0);
    chk(fuse_ctrl_o == 14'h0001, "R1 idle word after session", fuse_ctrl_o, 1);
    chk(flag_o == exp_flag, "R10 flag value", flag_o, exp_flag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(fuse_ctrl_o == 14'h0001, "R1 reset ctrl", fuse_ctrl_o, 1);
    chk(!busy_o && !done_o, "R1 reset busy/done", {busy_o, done_o}, 0);
    chk(!byte_valid_o, "R1 reset valid", byte_valid_o, 0);
    chk(flag_o == 2'b00, "R1 reset flag", flag_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(fuse_ctrl_o == 14'h0001 && !busy_o, "R1 idle after reset", fuse_ctrl_o, 1);
    // R7 zero count, R10 flag untouched
    run_session(8'h40, 0, 1'b0);
    // count sweep, R5 R6 R10 below and above flag index
    for (int n = 1; n <= 7; n++) run_session(8'(n * 37), n, 1'b0);
    // R5 wrap past 255
    run_session(8'hFB, 10, 1'b0);
    // R10 short session keeps earlier flag
    run_session(8'h10, 2, 1'b0);
    // R8 start while busy is ignored
    run_session(8'h80, 5, 1'b1);
    // whole address space
    run_session(8'h00, 256, 1'b0);
    run_session(8'h22, 0, 1'b0);
    summary();
    $finish;
  end
endmodule